// File: doc/BRIEF.md
# Aligned Mantissa Add/Subtract with Iterative Normaliser

This block is the accumulate half of a fused multiply-add datapath. It receives an addend (sign, exponent, 53-bit mantissa with hidden bit) and a product (sign, exponent, 56-bit mantissa that already holds guard, round and sticky positions). It brings both onto one exponent, adds or subtracts the magnitudes according to the two signs, and hands a normalised, still unrounded 56-bit mantissa to a later rounding and packing stage.

Alignment and the add/subtract are combinational and are captured on the cycle an operation is accepted. After that, a left normaliser moves the mantissa up one bit per clock, decrementing the exponent, until the top bit is set. A single-cycle `done` pulse marks valid outputs, which then hold until the next accepted operation. A new operation is taken only when the unit is idle. Exponents are two's complement and unbiased.

Top module: `addnorm_top`

## Requirements
- R1: The addend mantissa is extended with three zero bits below its LSB (addend value `m` becomes `m<<3`) before any alignment, so an addend `1<<52` with equal exponents lines up with a product mantissa `1<<55`.
- R2: The operand with the smaller exponent is shifted right by the exponent gap, every bit shifted out is ORed into bit 0, and the result exponent starts from the larger exponent.
- R3: A gap greater than 63 is treated as 63, so any nonzero smaller operand is reduced to a lone sticky bit in bit 0.
- R4: With equal signs the aligned mantissas are added; a carry out of bit 55 shifts the sum right by one place with bit 0 kept sticky, and raises the exponent by one.
- R5: With different signs the smaller aligned magnitude is subtracted from the larger, and the result sign is that of the larger one (the addend's sign when the magnitudes tie before the zero rule applies).
- R6: An exact-zero result sets `res_zero`, gives mantissa 0 and exponent 0, and its sign is 1 only for rounding mode 3 (toward minus infinity); modes 0 nearest, 1 toward zero and 2 toward plus infinity give sign 0.
- R7: A nonzero result is shifted left one bit per cycle, exponent decremented each step, until bit 55 is set; `done` rises N+2 clock edges after the accepting edge counted as edge 1 … i.e. on the (N+2)-th rising edge counting the accepting one, where N is the number of left shifts.
- R8: `done` is high for exactly one cycle, and the result outputs keep their values afterwards until a new operation is accepted.
- R9: `start` asserted while `busy` is high is ignored; the running operation completes with its own result.
- R10: After reset `busy`, `done`, `res_zero`, `res_sign`, `res_exp` and `res_mant` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation when idle |
| add_sign | input | 1 | Addend sign |
| add_exp | input | 13 | Addend exponent, two's complement |
| add_mant | input | 53 | Addend mantissa including hidden bit |
| prd_sign | input | 1 | Product sign |
| prd_exp | input | 13 | Product exponent, two's complement |
| prd_mant | input | 56 | Product mantissa with guard/round/sticky |
| rmode | input | 2 | Rounding mode: 0 nearest, 1 to zero, 2 to +inf, 3 to -inf |
| busy | output | 1 | Normaliser running |
| done | output | 1 | One-cycle pulse, outputs valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 13 | Result exponent |
| res_mant | output | 56 | Normalised unrounded mantissa |
| res_zero | output | 1 | Exact-zero result |

## Verification
The bench aims at gaps of exactly zero, small, just beyond the mantissa width and far beyond 63, where a design that dropped shifted-out bits would lose the sticky LSB and a design without saturation would shift by a wrapped amount and keep a large part of the operand. Near-total cancellation drives long normalisation runs, exposing a wrong exponent decrement or a latency that does not track the shift count. Exact cancellation is run in all four rounding modes to catch a zero of the wrong sign, and carry-out sums catch a missing exponent increment or a lost sticky bit. A start pulse during a long run checks that a design reloading while busy would corrupt the result.

// File: rtl/addnorm_pkg.sv
package addnorm_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_TOZERO  = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_NORM = 1'b1
  } nstate_e;
endpackage

// File: rtl/addnorm_align.sv
module addnorm_align #(
  parameter int AW  = 53,
  parameter int PW  = 56,
  parameter int EW  = 13,
  parameter int SHW = 6
) (
  input  logic signed [EW-1:0] a_exp,
  input  logic        [AW-1:0] a_mant,
  input  logic signed [EW-1:0] p_exp,
  input  logic        [PW-1:0] p_mant,
  output logic signed [EW-1:0] big_exp,
  output logic        [PW-1:0] a_al,
  output logic        [PW-1:0] p_al,
  output logic        [SHW-1:0] gap_sat
);
  localparam int GRS = PW - AW;
  localparam int SAT = (1 << SHW) - 1;
  localparam int MW  = PW + (1 << SHW);

  // right shift that folds every dropped bit into bit 0
  function automatic logic [PW-1:0] shr_sticky(input logic [PW-1:0] v, input logic [SHW-1:0] s);
    logic [MW-1:0] mask;
    logic [PW-1:0] o;
    mask = (MW'(1) << s) - MW'(1);
    o    = v >> s;
    o[0] = o[0] | (|(v & mask[PW-1:0]));
    return o;
  endfunction

  logic signed [EW:0] diff;
  logic        [EW:0] mag;
  logic               a_bigger;
  logic        [PW-1:0] a_ext;

  always_comb begin
    a_ext    = {a_mant, {GRS{1'b0}}};
    diff     = {p_exp[EW-1], p_exp} - {a_exp[EW-1], a_exp};
    a_bigger = diff[EW];
    mag      = a_bigger ? -diff : diff;
    gap_sat  = (mag > (EW+1)'(SAT)) ? SHW'(SAT) : mag[SHW-1:0];
    big_exp  = a_bigger ? a_exp : p_exp;
    a_al     = a_bigger ? a_ext  : shr_sticky(a_ext, gap_sat);
    p_al     = a_bigger ? shr_sticky(p_mant, gap_sat) : p_mant;
  end
endmodule

// File: rtl/addnorm_addsub.sv
module addnorm_addsub #(
  parameter int PW = 56,
  parameter int EW = 13
) (
  input  logic                 a_sign,
  input  logic                 p_sign,
  input  logic        [PW-1:0] a_al,
  input  logic        [PW-1:0] p_al,
  input  logic signed [EW-1:0] exp_in,
  output logic        [PW-1:0] sum_mant,
  output logic signed [EW-1:0] sum_exp,
  output logic                 sum_sign,
  output logic                 sum_zero,
  output logic                 carry_out
);
  function automatic logic [PW-1:0] fold_carry(input logic [PW:0] s);
    logic [PW-1:0] o;
    o    = s[PW:1];
    o[0] = o[0] | s[0];
    return o;
  endfunction

  logic [PW:0] wide;
  logic        eff_sub;

  always_comb begin
    eff_sub   = a_sign ^ p_sign;
    wide      = '0;
    carry_out = 1'b0;
    sum_exp   = exp_in;
    sum_sign  = a_sign;
    if (!eff_sub) begin
      wide      = {1'b0, a_al} + {1'b0, p_al};
      carry_out = wide[PW];
      sum_mant  = carry_out ? fold_carry(wide) : wide[PW-1:0];
      if (carry_out) sum_exp = exp_in + EW'(1);
    end else if (a_al >= p_al) begin
      sum_mant = a_al - p_al;
    end else begin
      sum_mant = p_al - a_al;
      sum_sign = p_sign;
    end
    sum_zero = (sum_mant == '0);
  end
endmodule

// File: rtl/addnorm_shifter.sv
module addnorm_shifter
  import addnorm_pkg::*;
#(
  parameter int PW = 56,
  parameter int EW = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 ld_sign,
  input  logic signed [EW-1:0] ld_exp,
  input  logic        [PW-1:0] ld_mant,
  input  logic                 ld_zero,
  input  logic        [1:0]    rmode,
  output logic                 busy,
  output logic                 done,
  output logic                 sign_q,
  output logic signed [EW-1:0] exp_q,
  output logic        [PW-1:0] mant_q,
  output logic                 zero_q
);
  nstate_e state;
  logic    settled;

  assign busy    = (state == ST_NORM);
  assign settled = zero_q | mant_q[PW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      sign_q <= 1'b0;
      exp_q  <= '0;
      mant_q <= '0;
      zero_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (load) begin
          state  <= ST_NORM;
          zero_q <= ld_zero;
          mant_q <= ld_mant;
          if (ld_zero) begin
            sign_q <= (rmode_e'(rmode) == RM_DOWN);
            exp_q  <= '0;
          end else begin
            sign_q <= ld_sign;
            exp_q  <= ld_exp;
          end
        end
      end else if (settled) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else begin
        mant_q <= mant_q << 1;
        exp_q  <= exp_q - EW'(1);
      end
    end
  end

  // R7: every normalising step moves the mantissa up one place and the exponent down one
  a_r7_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !settled) |=> (mant_q == ($past(mant_q) << 1)) && (exp_q == $past(exp_q) - EW'(1)));

  // R7: results are only announced once normalised or zero
  a_r7_done_normal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mant_q[PW-1] || zero_q));

  // R8: done never lasts two cycles
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a zero result carries a cleared mantissa and exponent
  a_r6_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q) |-> (mant_q == '0) && (exp_q == '0));
endmodule

// File: rtl/addnorm_top.sv
module addnorm_top #(
  parameter int AW  = 53,
  parameter int EW  = 13,
  parameter int SHW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 add_sign,
  input  logic signed [EW-1:0] add_exp,
  input  logic [AW-1:0]        add_mant,
  input  logic                 prd_sign,
  input  logic signed [EW-1:0] prd_exp,
  input  logic [AW+2:0]        prd_mant,
  input  logic [1:0]           rmode,
  output logic                 busy,
  output logic                 done,
  output logic                 res_sign,
  output logic signed [EW-1:0] res_exp,
  output logic [AW+2:0]        res_mant,
  output logic                 res_zero
);
  localparam int PW = AW + 3;

  logic signed [EW-1:0] big_exp, sum_exp;
  logic [PW-1:0]        a_al, p_al, sum_mant;
  logic [SHW-1:0]       gap_sat;
  logic                 sum_sign, sum_zero, carry_out, load;

  assign load = start & ~busy;

  addnorm_align #(.AW(AW), .PW(PW), .EW(EW), .SHW(SHW)) u_align (
    .a_exp(add_exp), .a_mant(add_mant), .p_exp(prd_exp), .p_mant(prd_mant),
    .big_exp(big_exp), .a_al(a_al), .p_al(p_al), .gap_sat(gap_sat)
  );

  addnorm_addsub #(.PW(PW), .EW(EW)) u_addsub (
    .a_sign(add_sign), .p_sign(prd_sign), .a_al(a_al), .p_al(p_al),
    .exp_in(big_exp), .sum_mant(sum_mant), .sum_exp(sum_exp),
    .sum_sign(sum_sign), .sum_zero(sum_zero), .carry_out(carry_out)
  );

  addnorm_shifter #(.PW(PW), .EW(EW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_sign(sum_sign),
    .ld_exp(sum_exp), .ld_mant(sum_mant), .ld_zero(sum_zero), .rmode(rmode),
    .busy(busy), .done(done), .sign_q(res_sign), .exp_q(res_exp),
    .mant_q(res_mant), .zero_q(res_zero)
  );

  // R4: a carrying sum is already normalised on the first working cycle
  a_r4_carry_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (load && carry_out) |=> res_mant[PW-1] && busy);

  // R9: a start during a running shift does not restart the operation
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !res_zero && !res_mant[PW-1]) |=> (res_exp == $past(res_exp) - EW'(1)));

  // R3: the applied gap never exceeds the saturation limit when exponents are far apart
  a_r3_gap_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ((add_exp - prd_exp > 63) || (prd_exp - add_exp > 63))) |-> (gap_sat == SHW'((1 << SHW) - 1)));
endmodule

// File: tb/sim_addnorm_top.sv
`timescale 1ns/1ps
module sim_addnorm_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic add_sign = 1'b0, prd_sign = 1'b0;
  logic signed [12:0] add_exp = '0, prd_exp = '0;
  logic [52:0] add_mant = '0;
  logic [55:0] prd_mant = '0;
  logic [1:0]  rmode = '0;
  logic busy, done, res_sign, res_zero;
  logic signed [12:0] res_exp;
  logic [55:0] res_mant;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addnorm_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .add_sign(add_sign), .add_exp(add_exp),
    .add_mant(add_mant), .prd_sign(prd_sign), .prd_exp(prd_exp), .prd_mant(prd_mant),
    .rmode(rmode), .busy(busy), .done(done), .res_sign(res_sign), .res_exp(res_exp),
    .res_mant(res_mant), .res_zero(res_zero)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference: bit-serial alignment, wide add, loop normalisation
  task automatic model(input bit as, input int ae, input logic [52:0] am,
                       input bit ps, input int pe, input logic [55:0] pm, input logic [1:0] rm,
                       output bit es, output int ee, output logic [55:0] em, output bit ez, output int nsh);
    logic [55:0] x, y, m;
    logic [56:0] s;
    int d, k;
    bit st;
    x = {am, 3'b000}; y = pm; d = pe - ae; st = 0; nsh = 0;
    if (d > 0) begin
      k = (d > 63) ? 63 : d;
      for (int i = 0; i < k; i++) begin st = st | x[0]; x = x >> 1; end
      x[0] = x[0] | st; ee = pe;
    end else begin
      k = (-d > 63) ? 63 : -d;
      for (int i = 0; i < k; i++) begin st = st | y[0]; y = y >> 1; end
      y[0] = y[0] | st; ee = ae;
    end
    es = as;
    if (as == ps) begin
      s = {1'b0, x} + {1'b0, y};
      if (s[56]) begin m = s[56:1]; m[0] = m[0] | s[0]; ee = ee + 1; end
      else m = s[55:0];
    end else if (x >= y) m = x - y;
    else begin m = y - x; es = ps; end
    ez = (m == 0);
    if (ez) begin es = (rm == 2'd3); ee = 0; end
    else while (!m[55]) begin m = m << 1; ee = ee - 1; nsh++; end
    em = m;
  endtask

  task automatic run_op(input bit as, input int ae, input logic [52:0] am,
                        input bit ps, input int pe, input logic [55:0] pm,
                        input logic [1:0] rm, input string tag);
    bit es, ez; int ee, nsh, cnt; logic [55:0] em;
    model(as, ae, am, ps, pe, pm, rm, es, ee, em, ez, nsh);
    @(negedge clk);
    add_sign = as; add_exp = 13'(ae); add_mant = am;
    prd_sign = ps; prd_exp = 13'(pe); prd_mant = pm; rmode = rm; start = 1'b1;
    @(posedge clk); cnt = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cnt < 100) begin @(posedge clk); cnt++; #1; end
    chk(done, {tag, " R7 done"}, 64'(done), 64'd1);
    chk(cnt == nsh + 2, {tag, " R7 latency"}, 64'(cnt), 64'(nsh + 2));
    chk(res_mant == em, {tag, " mant"}, 64'(res_mant), 64'(em));
    chk(res_exp == 13'(ee), {tag, " exp"}, 64'(res_exp), 64'(13'(ee)));
    chk(res_sign == es, {tag, " R5/R6 sign"}, 64'(res_sign), 64'(es));
    chk(res_zero == ez, {tag, " R6 zero"}, 64'(res_zero), 64'(ez));
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] hold_m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(!busy && !done && !res_zero && !res_sign, "R10 flags", {60'd0, busy, done, res_zero, res_sign}, 64'd0);
    chk(res_mant == 0 && res_exp == 0, "R10 data", 64'(res_mant), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: 1.0 addend, zero product -> 1<<55 exactly
    run_op(0, 0, 53'd1 << 52, 0, 0, 56'd0, 2'd0, "R1 shift3");
    // R1/R4: 1.0 + 1.0 carries
    run_op(0, 5, 53'd1 << 52, 0, 5, 56'd1 << 55, 2'd0, "R4 carry");
    // R4 carry with odd LSB -> sticky retained
    run_op(1, -3, {1'b1, 52'hF_FFFF_FFFF_FFFF}, 1, -3, {1'b1, 55'h7F_FFFF_FFFF_FFFF}, 2'd1, "R4 sticky");
    // R2 small gaps both ways
    run_op(0, 10, {1'b1, 52'h1_2345_6789_ABCD}, 0, 3, {1'b1, 55'h12_3456_789A_BCDF}, 2'd0, "R2 addend big");
    run_op(0, -20, {1'b1, 52'h8_0000_0000_0001}, 0, -1, {1'b1, 55'h0}, 2'd2, "R2 product big");
    run_op(0, 0, {1'b1, 52'h0}, 1, 57, {1'b1, 55'h0}, 2'd0, "R2 gap57");
    // R3 saturation
    run_op(0, -1000, {1'b1, 52'hABCD}, 0, 1000, {1'b1, 55'h0}, 2'd0, "R3 far");
    run_op(1, 1500, {1'b1, 52'h0}, 0, -1500, 56'h1, 2'd0, "R3 far sub");
    // R5 sign of larger
    run_op(1, 0, {1'b1, 52'h0}, 0, 0, {1'b1, 55'h1}, 2'd0, "R5 prd larger");
    run_op(1, 2, {1'b1, 52'h0}, 0, 0, {1'b1, 55'h1}, 2'd0, "R5 add larger");
    // R6 exact cancellation in each mode
    for (int r = 0; r < 4; r++)
      run_op(0, 7, {1'b1, 52'h3_3333}, 1, 7, {1'b1, 52'h3_3333, 3'b000}, 2'(r), "R6 cancel");
    // R7 long normalisation
    run_op(0, 0, {1'b1, 52'h0}, 1, 0, (56'd1 << 55) | 56'd1, 2'd0, "R7 long");

    // R8: outputs hold after the pulse
    hold_m = res_mant;
    @(posedge clk); #1;
    chk(!done, "R8 pulse", 64'(done), 64'd0);
    chk(res_mant == hold_m, "R8 hold", 64'(res_mant), 64'(hold_m));

    // R9: start while busy ignored; result is 1<<40 normalised, 15 shifts
    begin
      int cnt;
      @(negedge clk);
      add_sign = 1; add_exp = 0; add_mant = 53'd1 << 52;
      prd_sign = 0; prd_exp = 0; prd_mant = (56'd1 << 55) | (56'd1 << 40); start = 1'b1;
      @(posedge clk); cnt = 1;
      @(negedge clk);
      add_sign = 0; add_exp = 100; prd_sign = 0; prd_exp = 100;
      @(posedge clk); cnt++;
      @(posedge clk); cnt++;
      @(negedge clk); start = 1'b0;
      while (!done && cnt < 100) begin @(posedge clk); cnt++; #1; end
      chk(res_mant == (56'd1 << 55) && res_exp == -13'sd15 && res_sign == 0,
          "R9 busy start", 64'(res_exp), 64'(-15));
    end

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int ae, pe, g;
      logic [55:0] pm;
      logic [52:0] am;
      ae = int'($urandom_range(2000)) - 1000;
      g  = int'($urandom_range(140)) - 70;
      if (i % 10 == 0) g = g * 30;
      pe = ae + g;
      am = {1'b1, 20'($urandom), 32'($urandom)};
      pm = {1'b1, 23'($urandom), 32'($urandom)};
      if (i % 4 == 0) begin pe = ae; pm = {am, 3'($urandom)} ^ 56'($urandom_range(255)); end
      run_op(1'($urandom), ae, am, 1'($urandom), pe, pm, 2'($urandom), "rand R2/R4/R5/R7");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule